// File: doc/BRIEF.md
# Condition Code Flag Generator

This block is the flag stage of a 32-bit integer datapath. An operation code selects one of the following:

- a flag update for an already formed logic result;
- an addition or a subtraction;
- an addition or a subtraction that also folds in the incoming extend bit;
- a compare whose flags are taken at byte or at halfword width.

The block returns the 32-bit result together with the negative (N), zero (Z), overflow (V), carry/borrow (C) and extend (X) flags. It has no storage and settles within the same cycle as its inputs.

The extend forms exist for multi-word arithmetic. The caller feeds the previous X and Z back in. A zero result from an extend operation leaves Z as it was, so a chain of word operations reports zero only when every word was zero. The compares run the full 32-bit subtraction, but derive every flag from the low 8 or 16 bits. They leave X untouched.

Top module: `cc_flag_gen`

## Requirements
- R1: `op_i` encodes the operation: 0 logic, 1 add, 2 subtract, 3 add with extend, 4 subtract with extend, 5 byte compare, 6 halfword compare, 7 reserved.
- R2: Logic (code 0). The result equals `a_i`. N is result bit 31 and Z is set for a zero result. C and V are 0, and X equals `x_i`.
- R3: Add (code 1). The result is `a_i + b_i` modulo 2^32. C is set when the result is unsigned-less-than `b_i`. V is set when both operands share a sign that the result does not.
- R4: Subtract (code 2). The result is `a_i - b_i`. C is set when `a_i` is unsigned-less-than `b_i`. V is set when the operand signs differ and the result sign differs from `a_i`.
- R5: Add with extend (code 3). The result is `a_i + b_i + x_i`. When `x_i` is 1, C is set if the result is unsigned-less-or-equal to `b_i`; otherwise C follows R3. V follows R3.
- R6: Subtract with extend (code 4). The result is `a_i - b_i - x_i`. When `x_i` is 1, C is set if `a_i` is unsigned-less-or-equal to `b_i`; otherwise C follows R4. V follows R4.
- R7: For codes 3 and 4, `z_o` is `z_i` AND (result == 0). A nonzero result clears Z, and a zero result keeps `z_i`.
- R8: For codes 1 to 4, `x_o` equals `c_o`. For all other codes, `x_o` equals `x_i`.
- R9: Byte compare (code 5). The result is `a_i - b_i` over 32 bits. N, Z, C and V follow the subtract rules applied to bits 7:0 only, with the sign taken from bit 7. X is unchanged.
- R10: Halfword compare (code 6) behaves as R9 but on bits 15:0, with the sign taken from bit 15.
- R11: Reserved code 7 produces exactly the outputs of the logic operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code (R1) |
| a_i | input | 32 | First operand / logic result |
| b_i | input | 32 | Second operand |
| x_i | input | 1 | Incoming extend bit |
| z_i | input | 1 | Incoming zero flag (used by extend forms) |
| result_o | output | 32 | Arithmetic result |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| c_o | output | 1 | Carry / borrow flag |
| x_o | output | 1 | Extend flag |

## Verification
Every operation code is run over every pair drawn from a set of corner operands, with both values of `x_i` and `z_i`.

- The pairs 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF separate the carry and overflow rules at the 32-bit boundary.
- The values 0x7F/0x80/0xFF and 0x7FFF/0x8000/0xFFFF, with noise in the upper bits, show whether the compares really take sign and borrow at bit 7 or bit 15 rather than bit 31.
- Equal operands with `x_i` set distinguish the "less-or-equal" carry of the extend forms from the plain one.
- Zero extend results with `z_i` clear show that Z can be cleared but never set.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [2:0] {
    CC_LOGIC = 3'd0,
    CC_ADD   = 3'd1,
    CC_SUB   = 3'd2,
    CC_ADDX  = 3'd3,
    CC_SUBX  = 3'd4,
    CC_CMPB  = 3'd5,
    CC_CMPW  = 3'd6,
    CC_RSVD  = 3'd7
  } cc_op_e;

  localparam int unsigned NARROW_N = 2;  // byte and halfword compares
  localparam int unsigned NARROW_BASE_W = 8;
endpackage

// File: rtl/cc_adder.sv
module cc_adder #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] full;
  always_comb begin
    full   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    sum_o  = full[W-1:0];
    cout_o = full[W];
  end
endmodule

// File: rtl/cc_flag_calc.sv
module cc_flag_calc #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] beff_i,  // b, or ~b for subtraction
  input  logic [W-1:0] sum_i,
  output logic         n_o,
  output logic         z_o,
  output logic         v_o
);
  always_comb begin
    n_o = sum_i[W-1];
    z_o = (sum_i == '0);
    // signed overflow: addends share a sign the sum lost
    v_o = (a_i[W-1] == beff_i[W-1]) && (sum_i[W-1] != a_i[W-1]);
  end
endmodule

// File: rtl/cc_flag_gen.sv
module cc_flag_gen
  import cc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              x_i,
  input  logic              z_i,
  output logic [DATA_W-1:0] result_o,
  output logic              n_o,
  output logic              z_o,
  output logic              v_o,
  output logic              c_o,
  output logic              x_o
);
  cc_op_e op;
  logic   is_sub, is_ext, is_arith, is_cmp;
  logic   cin;
  logic [DATA_W-1:0] b_eff, sum;
  logic   cout, m_n, m_z, m_v, m_c;

  logic [NARROW_N-1:0] nr_n, nr_z, nr_v, nr_c;

  always_comb begin
    op       = cc_op_e'(op_i);
    is_sub   = (op == CC_SUB) || (op == CC_SUBX) || (op == CC_CMPB) || (op == CC_CMPW);
    is_ext   = (op == CC_ADDX) || (op == CC_SUBX);
    is_arith = (op == CC_ADD) || (op == CC_SUB) || is_ext;
    is_cmp   = (op == CC_CMPB) || (op == CC_CMPW);
    b_eff    = is_sub ? ~b_i : b_i;
    unique case (op)
      CC_ADDX: cin = x_i;
      CC_SUBX: cin = ~x_i;
      CC_SUB, CC_CMPB, CC_CMPW: cin = 1'b1;
      default: cin = 1'b0;
    endcase
  end

  cc_adder #(.W(DATA_W)) u_add_main (
    .a_i(a_i), .b_i(b_eff), .cin_i(cin), .sum_o(sum), .cout_o(cout)
  );

  cc_flag_calc #(.W(DATA_W)) u_flag_main (
    .a_i(a_i), .beff_i(b_eff), .sum_i(sum), .n_o(m_n), .z_o(m_z), .v_o(m_v)
  );

  assign m_c = is_sub ? ~cout : cout;

  // narrow compare lanes: 8 and 16 bits, always subtract
  for (genvar g = 0; g < NARROW_N; g++) begin : g_narrow
    localparam int unsigned NW = NARROW_BASE_W << g;
    logic [NW-1:0] nb, ns;
    logic          nco;
    assign nb = ~b_i[NW-1:0];
    cc_adder #(.W(NW)) u_add (
      .a_i(a_i[NW-1:0]), .b_i(nb), .cin_i(1'b1), .sum_o(ns), .cout_o(nco)
    );
    cc_flag_calc #(.W(NW)) u_flag (
      .a_i(a_i[NW-1:0]), .beff_i(nb), .sum_i(ns),
      .n_o(nr_n[g]), .z_o(nr_z[g]), .v_o(nr_v[g])
    );
    assign nr_c[g] = ~nco;
  end

  always_comb begin
    result_o = a_i;
    n_o      = a_i[DATA_W-1];
    z_o      = (a_i == '0);
    v_o      = 1'b0;
    c_o      = 1'b0;
    x_o      = x_i;
    if (is_arith || is_cmp) result_o = sum;
    if (is_arith) begin
      n_o = m_n;
      z_o = is_ext ? (m_z & z_i) : m_z;
      v_o = m_v;
      c_o = m_c;
      x_o = m_c;
    end else if (is_cmp) begin
      n_o = (op == CC_CMPB) ? nr_n[0] : nr_n[1];
      z_o = (op == CC_CMPB) ? nr_z[0] : nr_z[1];
      v_o = (op == CC_CMPB) ? nr_v[0] : nr_v[1];
      c_o = (op == CC_CMPB) ? nr_c[0] : nr_c[1];
    end
  end
endmodule

// File: rtl/cc_flag_gen_chk.sv
module cc_flag_gen_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              x_i,
  input logic              z_i,
  input logic [DATA_W-1:0] result_o,
  input logic              n_o,
  input logic              z_o,
  input logic              v_o,
  input logic              c_o,
  input logic              x_o
);
  always_comb begin
    if (op_i == 3'd0 || op_i == 3'd7) begin
      AST_LOGIC_CV_CLEAR: assert (!c_o && !v_o && result_o == a_i)
        else $error("logic flags");  // R2
    end
    if (op_i >= 3'd1 && op_i <= 3'd4) begin
      AST_X_FOLLOWS_C: assert (x_o == c_o) else $error("x != c");  // R8
    end else begin
      AST_X_HELD: assert (x_o == x_i) else $error("x changed");  // R8
    end
    if ((op_i == 3'd3 || op_i == 3'd4) && !z_i) begin
      AST_Z_NEVER_SET: assert (!z_o) else $error("sticky z set");  // R7
    end
    if (op_i == 3'd2) begin
      AST_SUB_RESULT: assert (result_o + b_i == a_i) else $error("sub result");  // R4
    end
    if (op_i == 3'd5) begin
      AST_CMPB_Z: assert (z_o == (a_i[7:0] == b_i[7:0])) else $error("cmpb z");  // R9
    end
    if (op_i == 3'd6) begin
      AST_CMPW_C: assert (c_o == (a_i[15:0] < b_i[15:0])) else $error("cmpw c");  // R10
    end
  end
endmodule

bind cc_flag_gen cc_flag_gen_chk #(.DATA_W(DATA_W)) u_chk (
  .op_i(op_i), .a_i(a_i), .b_i(b_i), .x_i(x_i), .z_i(z_i),
  .result_o(result_o), .n_o(n_o), .z_o(z_o), .v_o(v_o), .c_o(c_o), .x_o(x_o)
);

// File: tb/cc_flag_gen_tb.sv
module cc_flag_gen_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        x_i = 1'b0, z_i = 1'b0;
  logic [31:0] result_o;
  logic        n_o, z_o, v_o, c_o, x_o;
  int          checks = 0, failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  cc_flag_gen u_dut (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .x_i(x_i), .z_i(z_i),
    .result_o(result_o), .n_o(n_o), .z_o(z_o), .v_o(v_o), .c_o(c_o), .x_o(x_o)
  );

  localparam int NCORN = 12;
  function automatic logic [31:0] corner(input int i);
    case (i)
      0: return 32'h0000_0000;   1: return 32'h0000_0001;
      2: return 32'h7FFF_FFFF;   3: return 32'h8000_0000;
      4: return 32'hFFFF_FFFF;   5: return 32'h1234_567F;
      6: return 32'hABCD_0080;   7: return 32'h0000_00FF;
      8: return 32'h5A5A_7FFF;   9: return 32'hC3C3_8000;
      10: return 32'h0000_FFFF;  default: return 32'h8765_4321;
    endcase
  endfunction

  // expected {result, n, z, v, c, x}
  function automatic logic [36:0] ref_model(input logic [2:0] op, input logic [31:0] a,
                                            input logic [31:0] b, input logic xi, input logic zi);
    logic [31:0] r; logic n, z, v, c, x;
    logic [7:0] a8, b8, r8; logic [15:0] a16, b16, r16;
    r = a; n = a[31]; z = (a == 0); v = 0; c = 0; x = xi;
    case (op)
      3'd1: begin r = a + b; c = (r < b); v = (a[31] == b[31]) && (r[31] != a[31]);
                  n = r[31]; z = (r == 0); x = c; end
      3'd2: begin r = a - b; c = (a < b); v = (a[31] != b[31]) && (r[31] != a[31]);
                  n = r[31]; z = (r == 0); x = c; end
      3'd3: begin r = a + b + {31'd0, xi}; c = xi ? (r <= b) : (r < b);
                  v = (a[31] == b[31]) && (r[31] != a[31]);
                  n = r[31]; z = (r == 0) && zi; x = c; end
      3'd4: begin r = a - b - {31'd0, xi}; c = xi ? (a <= b) : (a < b);
                  v = (a[31] != b[31]) && (r[31] != a[31]);
                  n = r[31]; z = (r == 0) && zi; x = c; end
      3'd5: begin r = a - b; a8 = a[7:0]; b8 = b[7:0]; r8 = a8 - b8;
                  c = (a8 < b8); v = (a8[7] != b8[7]) && (r8[7] != a8[7]);
                  n = r8[7]; z = (r8 == 0); end
      3'd6: begin r = a - b; a16 = a[15:0]; b16 = b[15:0]; r16 = a16 - b16;
                  c = (a16 < b16); v = (a16[15] != b16[15]) && (r16[15] != a16[15]);
                  n = r16[15]; z = (r16 == 0); end
      default: ;
    endcase
    return {r, n, z, v, c, x};
  endfunction

  task automatic check_one(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                           input logic xi, input logic zi, input string req);
    logic [36:0] exp, act;
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; x_i = xi; z_i = zi;
    #2;
    exp = ref_model(op, a, b, xi, zi);
    act = {result_o, n_o, z_o, v_o, c_o, x_o};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s op=%0d a=%h b=%h x=%b z=%b actual=%h expected=%h",
               req, op, a, b, xi, zi, act, exp);
    end
  endtask

  task automatic sweep(input logic [2:0] op, input string req);
    for (int i = 0; i < NCORN; i++)
      for (int j = 0; j < NCORN; j++)
        for (int k = 0; k < 4; k++)
          check_one(op, corner(i), corner(j), k[0], k[1], req);
  endtask

  task automatic t_logic;    sweep(3'd0, "R2"); endtask
  task automatic t_add;      sweep(3'd1, "R3/R8"); endtask
  task automatic t_sub;      sweep(3'd2, "R4/R8"); endtask
  task automatic t_addx;     sweep(3'd3, "R5/R7"); endtask
  task automatic t_subx;     sweep(3'd4, "R6/R7"); endtask
  task automatic t_cmpb;     sweep(3'd5, "R9"); endtask
  task automatic t_cmpw;     sweep(3'd6, "R10"); endtask
  task automatic t_reserved; sweep(3'd7, "R11"); endtask

  // directed boundary points, expected values written out
  task automatic t_directed;
    logic [36:0] act;
    // R5: ffffffff + 0 + 1 = 0, C=1, Z keeps z_i=1, X=C
    @(negedge clk); op_i = 3'd3; a_i = '1; b_i = '0; x_i = 1; z_i = 1; #2;
    act = {result_o, n_o, z_o, v_o, c_o, x_o}; checks++;
    if (act !== {32'h0, 5'b01011}) begin failures++;
      $display("FAIL R5/R7 actual=%h expected=%h", act, {32'h0, 5'b01011}); end
    // R7: same but z_i=0 -> Z stays 0
    @(negedge clk); z_i = 0; #2;
    checks++;
    if (z_o !== 1'b0) begin failures++;
      $display("FAIL R7 actual=%b expected=0", z_o); end
    // R6: 5 - 5 - 1 = ffffffff, C=1 (a<=b), N=1
    @(negedge clk); op_i = 3'd4; a_i = 5; b_i = 5; x_i = 1; z_i = 1; #2;
    act = {result_o, n_o, z_o, v_o, c_o, x_o}; checks++;
    if (act !== {32'hFFFF_FFFF, 5'b10011}) begin failures++;
      $display("FAIL R6 actual=%h expected=%h", act, {32'hFFFF_FFFF, 5'b10011}); end
    // R9: byte compare 0x80 - 0x01: V=1, N=0, X held at 0
    @(negedge clk); op_i = 3'd5; a_i = 32'h0000_0080; b_i = 1; x_i = 0; #2;
    act = {result_o, n_o, z_o, v_o, c_o, x_o}; checks++;
    if (act !== {32'h7F, 5'b00100}) begin failures++;
      $display("FAIL R9 actual=%h expected=%h", act, {32'h7F, 5'b00100}); end
    // R1/R3: 7fffffff + 1 overflows
    @(negedge clk); op_i = 3'd1; a_i = 32'h7FFF_FFFF; b_i = 1; #2;
    act = {result_o, n_o, z_o, v_o, c_o, x_o}; checks++;
    if (act !== {32'h8000_0000, 5'b10100}) begin failures++;
      $display("FAIL R1/R3 actual=%h expected=%h", act, {32'h8000_0000, 5'b10100}); end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    // idle inputs: logic op on zero -> Z only
    check_one(3'd0, '0, '0, 1'b0, 1'b0, "R2");
    t_directed;
    t_logic;
    t_add;
    t_sub;
    t_addx;
    t_subx;
    t_cmpb;
    t_cmpw;
    t_reserved;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule